// File: doc/BRIEF.md
# Speculation Error Compensator

This unit sits behind a block-speculative adder. That adder splits a wide sum into equal sub-adder blocks and guesses the carry into each block. The unit receives the raw sum together with one error flag and one direction bit per block boundary. Flag bit j and direction bit j describe the boundary between block j (the lower block) and block j+1 (the upper block). A direction of 1 means the guessed carry was too low, so the raw sum is short by one unit of the upper block's weight. A direction of 0 means the guess was too high.

For each flagged boundary, the unit first tries an exact repair. It steps a small group of low bits of the upper block by one. If that step would wrap the group, the unit leaves the upper block alone. It then forces the top group of bits of the lower block in the opposite direction of the error. This shrinks the residual error to one unit at the bottom of that forced group.

Every boundary is handled on its own. A block can have its low group stepped by the boundary below it and its high group forced by the boundary above it, both for the same sample.

The datapath has two register stages. The first stage registers the per-boundary decisions and the second registers the finished sum. A valid bit travels alongside the data.

Top module: `spec_err_comp`

## Requirements
- R1: A sample presented with `in_valid`=1 at a rising edge appears on `out_sum` with `out_valid`=1 exactly two rising edges later. `out_valid` is 0 after reset and in every cycle that no accepted sample reaches it.
- R2: When every flag bit is 0, `out_sum` equals `in_sum` bit for bit.
- R3: Take a flagged boundary j with direction 1. Its correction group is the CORR_W bits of the upper block starting at bit (j+1)*BLK_W. If that group is not all ones, it is incremented by one without carry out of the group, and no other bit of the block changes. For an exact raw sum that was short by 2^((j+1)*BLK_W), the output equals the exact sum.
- R4: Take a flagged boundary j with direction 0. If its correction group is not all zeros, the group is decremented by one without borrow out of the group. For an exact raw sum that was high by 2^((j+1)*BLK_W), the output equals the exact sum.
- R5: Take a flagged boundary j with direction 1 whose correction group is all ones. The correction group is left unchanged. The balancing group, which is the top BAL_W bits of lower block j ending at bit (j+1)*BLK_W-1, is set to all ones.
- R6: Take a flagged boundary j with direction 0 whose correction group is all zeros. The correction group is left unchanged and the balancing group of lower block j is cleared to all zeros.
- R7: Suppose a balancing step flips a balancing group whose bits all held the opposite value. Then the output differs from the exact sum by exactly 2^((j+1)*BLK_W-BAL_W), one unit of the balancing group's lowest bit.
- R8: Boundaries act independently. A block whose correction group is stepped by the boundary below it and whose balancing group is forced by the boundary above it carries both edits in the same output word.
- R9: A direction bit whose flag bit is 0 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample on the inputs is to be processed |
| in_sum | input | BLK_W*NUM_BLK | Raw speculative sum |
| in_err | input | NUM_BLK-1 | Per-boundary error flag; bit j is the boundary above block j |
| in_dir | input | NUM_BLK-1 | Per-boundary error direction; 1 = sum too low, 0 = sum too high |
| out_valid | output | 1 | `out_sum` holds a processed sample |
| out_sum | output | BLK_W*NUM_BLK | Corrected or balanced sum |

## Verification
Two edits can land on one block in the same cycle. One is the increment or decrement of its low group, driven by the boundary beneath it. The other is the forcing of its high group, driven by the boundary above it. The bench provokes this by flagging two adjacent boundaries in one sample, with a raw word whose upper correction group is all zeros so the upper boundary must fall back to balancing. It judges the result by predicting the output word with both edits applied, and by confirming each edit in its own bit range. Exact-sum cases and residual-error magnitudes are checked separately against true addition results.

// File: rtl/sec_pkg.sv
package sec_pkg;

  // Edit applied to a block's low correction group
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_INC  = 2'd1,
    CORR_DEC  = 2'd2
  } corr_op_t;

  // Edit applied to a block's high balancing group
  typedef enum logic [1:0] {
    BAL_NONE = 2'd0,
    BAL_SET  = 2'd1,
    BAL_CLR  = 2'd2
  } bal_op_t;

endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/sec_decide.sv
module sec_decide
  import sec_pkg::*;
#(
  parameter int CORR_W = 2
) (
  input  logic              flag,
  input  logic              dir_up,
  input  logic [CORR_W-1:0] lsb_grp,
  output corr_op_t          corr_op,
  output bal_op_t           bal_op
);

  logic grp_full;
  logic grp_empty;

  assign grp_full  = &lsb_grp;
  assign grp_empty = ~|lsb_grp;

  // The flag steers between pass, exact step, and fallback balancing
  always_comb begin
    corr_op = CORR_NONE;
    bal_op  = BAL_NONE;
    if (flag) begin
      if (dir_up) begin
        if (!grp_full) corr_op = CORR_INC;
        else           bal_op  = BAL_SET;
      end else begin
        if (!grp_empty) corr_op = CORR_DEC;
        else            bal_op  = BAL_CLR;
      end
    end
  end

endmodule

// File: rtl/sec_apply.sv
module sec_apply
  import sec_pkg::*;
#(
  parameter int BLK_W  = 4,
  parameter int CORR_W = 2,
  parameter int BAL_W  = 2
) (
  input  logic [BLK_W-1:0] blk_in,
  input  corr_op_t         corr_op,
  input  bal_op_t          bal_op,
  output logic [BLK_W-1:0] blk_out
);

  localparam int BAL_LO = BLK_W - BAL_W;

  logic [CORR_W-1:0] lsb_in;
  logic [CORR_W-1:0] lsb_out;

  assign lsb_in = blk_in[CORR_W-1:0];

  always_comb begin
    unique case (corr_op)
      CORR_INC: lsb_out = lsb_in + CORR_W'(1);
      CORR_DEC: lsb_out = lsb_in - CORR_W'(1);
      default:  lsb_out = lsb_in;
    endcase
  end

  // Groups never overlap (CORR_W + BAL_W <= BLK_W), so both edits compose
  always_comb begin
    blk_out               = blk_in;
    blk_out[CORR_W-1:0]   = lsb_out;
    unique case (bal_op)
      BAL_SET: blk_out[BLK_W-1:BAL_LO] = '1;
      BAL_CLR: blk_out[BLK_W-1:BAL_LO] = '0;
      default: ;
    endcase
  end

endmodule

// File: rtl/spec_err_comp.sv
module spec_err_comp
  import sec_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int NUM_BLK = 4,
  parameter int CORR_W  = 2,
  parameter int BAL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [BLK_W*NUM_BLK-1:0]   in_sum,
  input  logic [NUM_BLK-2:0]         in_err,
  input  logic [NUM_BLK-2:0]         in_dir,
  output logic                       out_valid,
  output logic [BLK_W*NUM_BLK-1:0]   out_sum
);

  localparam int SUM_W   = BLK_W * NUM_BLK;
  localparam int NUM_BND = NUM_BLK - 1;
  localparam int BAL_LO  = BLK_W - BAL_W;

  logic rst_s_n;

  sec_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // ---------------- boundary decisions ----------------
  corr_op_t bnd_corr [NUM_BND];
  bal_op_t  bnd_bal  [NUM_BND];

  for (genvar j = 0; j < NUM_BND; j++) begin : g_bnd
    sec_decide #(.CORR_W(CORR_W)) u_dec (
      .flag    (in_err[j]),
      .dir_up  (in_dir[j]),
      .lsb_grp (in_sum[(j+1)*BLK_W +: CORR_W]),
      .corr_op (bnd_corr[j]),
      .bal_op  (bnd_bal[j])
    );

    // R3/R4/R5/R6: a boundary either steps or balances, never both
    assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
      in_valid |-> !((bnd_corr[j] != CORR_NONE) && (bnd_bal[j] != BAL_NONE)));
  end

  // Map boundary decisions onto per-block edits
  corr_op_t blk_corr [NUM_BLK];
  bal_op_t  blk_bal  [NUM_BLK];

  always_comb begin
    for (int k = 0; k < NUM_BLK; k++) begin
      blk_corr[k] = CORR_NONE;
      blk_bal[k]  = BAL_NONE;
    end
    for (int j = 0; j < NUM_BND; j++) begin
      blk_corr[j+1] = bnd_corr[j];
      blk_bal[j]    = bnd_bal[j];
    end
  end

  // ---------------- stage 1 ----------------
  logic             s1_valid, s1_valid_d;
  logic [SUM_W-1:0] s1_sum,   s1_sum_d;
  corr_op_t         s1_corr   [NUM_BLK];
  corr_op_t         s1_corr_d [NUM_BLK];
  bal_op_t          s1_bal    [NUM_BLK];
  bal_op_t          s1_bal_d  [NUM_BLK];

  always_comb begin
    s1_valid_d = in_valid;
    s1_sum_d   = in_valid ? in_sum : s1_sum;
    for (int k = 0; k < NUM_BLK; k++) begin
      s1_corr_d[k] = in_valid ? blk_corr[k] : s1_corr[k];
      s1_bal_d[k]  = in_valid ? blk_bal[k]  : s1_bal[k];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) s1_valid <= 1'b0;
    else          s1_valid <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    s1_sum  <= s1_sum_d;
    s1_corr <= s1_corr_d;
    s1_bal  <= s1_bal_d;
  end

  // ---------------- apply edits ----------------
  logic [SUM_W-1:0] app_sum;
  logic             s1_quiet;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    sec_apply #(.BLK_W(BLK_W), .CORR_W(CORR_W), .BAL_W(BAL_W)) u_app (
      .blk_in  (s1_sum[k*BLK_W +: BLK_W]),
      .corr_op (s1_corr[k]),
      .bal_op  (s1_bal[k]),
      .blk_out (app_sum[k*BLK_W +: BLK_W])
    );
  end

  always_comb begin
    s1_quiet = 1'b1;
    for (int k = 0; k < NUM_BLK; k++) begin
      if (s1_corr[k] != CORR_NONE || s1_bal[k] != BAL_NONE) s1_quiet = 1'b0;
    end
  end

  // ---------------- stage 2 ----------------
  logic             out_valid_d;
  logic [SUM_W-1:0] out_sum_d;

  always_comb begin
    out_valid_d = s1_valid;
    out_sum_d   = s1_valid ? app_sum : out_sum;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) out_valid <= 1'b0;
    else          out_valid <= out_valid_d;
  end

  always_ff @(posedge clk) begin
    out_sum <= out_sum_d;
  end

  // ---------------- checks ----------------
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> ##1 out_valid);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (s1_valid && s1_quiet) |=> (out_sum == $past(s1_sum)));

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_chk
    assert_no_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
      (s1_valid && s1_corr[k] == CORR_INC) |=> (out_sum[k*BLK_W +: CORR_W] != '0));

    assert_no_wrap_down_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
      (s1_valid && s1_corr[k] == CORR_DEC) |=> (out_sum[k*BLK_W +: CORR_W] != '1));

    assert_bal_high_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
      (s1_valid && s1_bal[k] == BAL_CLR) |=> (out_sum[k*BLK_W+BAL_LO +: BAL_W] == '0));

    // R8: stepping the low group leaves the high group of the same block intact
    assert_low_edit_keeps_high_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
      (s1_valid && s1_bal[k] == BAL_NONE) |=>
        (out_sum[k*BLK_W+BAL_LO +: BAL_W] == $past(s1_sum[k*BLK_W+BAL_LO +: BAL_W])));
  end

endmodule

// File: tb/spec_err_comp_bench.sv
module spec_err_comp_bench;

  localparam int BLK_W   = 4;
  localparam int NUM_BLK = 4;
  localparam int CORR_W  = 2;
  localparam int BAL_W   = 2;
  localparam int SUM_W   = BLK_W * NUM_BLK;
  localparam int NUM_BND = NUM_BLK - 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic [SUM_W-1:0]   in_sum;
  logic [NUM_BND-1:0] in_err;
  logic [NUM_BND-1:0] in_dir;
  logic               out_valid;
  logic [SUM_W-1:0]   out_sum;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  spec_err_comp #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .CORR_W(CORR_W), .BAL_W(BAL_W))
    u_spec_err_comp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sum(in_sum),
      .in_err(in_err), .in_dir(in_dir), .out_valid(out_valid), .out_sum(out_sum));

  // Prediction built from the requirement text
  function automatic logic [SUM_W-1:0] predict(input logic [SUM_W-1:0] raw,
                                               input logic [NUM_BND-1:0] flg,
                                               input logic [NUM_BND-1:0] dir);
    logic [SUM_W-1:0]  res;
    logic [CORR_W-1:0] grp;
    int ub;
    res = raw;
    for (int j = 0; j < NUM_BND; j++) begin
      if (flg[j]) begin
        ub  = (j + 1) * BLK_W;
        grp = raw[ub +: CORR_W];
        if (dir[j]) begin
          if (grp != '1) res[ub +: CORR_W] = grp + 1'b1;
          else           res[ub-BAL_W +: BAL_W] = '1;
        end else begin
          if (grp != '0) res[ub +: CORR_W] = grp - 1'b1;
          else           res[ub-BAL_W +: BAL_W] = '0;
        end
      end
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [SUM_W-1:0] act,
                       input logic [SUM_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Send one sample, then sample the output two edges later
  task automatic run_one(input logic [SUM_W-1:0] raw, input logic [NUM_BND-1:0] flg,
                         input logic [NUM_BND-1:0] dir, output logic [SUM_W-1:0] res);
    @(negedge clk);
    in_sum = raw; in_err = flg; in_dir = dir; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid low one edge after accept", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check("R1 out_valid high two edges after accept", {15'd0, out_valid}, 16'd1);
    res = out_sum;
  endtask

  task automatic t_reset;
    check("R1 out_valid after reset", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_pass;
    logic [SUM_W-1:0] r;
    run_one(16'hA5C3, 3'b000, 3'b000, r); check("R2 pass A5C3", r, 16'hA5C3);
    run_one(16'h0000, 3'b000, 3'b000, r); check("R2 pass 0000", r, 16'h0000);
    run_one(16'h3CF0, 3'b000, 3'b000, r); check("R2 pass 3CF0", r, 16'h3CF0);
  endtask

  task automatic t_dir_ignored;
    logic [SUM_W-1:0] r;
    run_one(16'hFFFF, 3'b000, 3'b111, r); check("R9 dir ignored FFFF", r, 16'hFFFF);
    run_one(16'h0000, 3'b000, 3'b101, r); check("R9 dir ignored 0000", r, 16'h0000);
  endtask

  task automatic t_inc;
    logic [SUM_W-1:0] r;
    // exact 1235 short by 2^4 -> raw 1225
    run_one(16'h1235 - 16'h0010, 3'b001, 3'b001, r);
    check("R3 increment restores exact sum", r, 16'h1235);
  endtask

  task automatic t_dec;
    logic [SUM_W-1:0] r;
    // exact 5A3C high by 2^12 -> raw 6A3C
    run_one(16'h5A3C + 16'h1000, 3'b100, 3'b000, r);
    check("R4 decrement restores exact sum", r, 16'h5A3C);
  endtask

  task automatic t_bal_up;
    logic [SUM_W-1:0] r;
    logic [SUM_W-1:0] exact;
    exact = 16'h0400;                       // raw 0300: group bits 9:8 all ones
    run_one(exact - 16'h0100, 3'b010, 3'b010, r);
    check("R5 balance sets lower MSBs", r, 16'h03C0);
    check("R7 residual after upward balance", exact - r, 16'h0040);
  endtask

  task automatic t_bal_down;
    logic [SUM_W-1:0] r;
    logic [SUM_W-1:0] exact;
    exact = 16'h00FC;                       // raw 010C: group bits 5:4 zero
    run_one(exact + 16'h0010, 3'b001, 3'b000, r);
    check("R6 balance clears lower MSBs", r, 16'h0100);
    check("R7 residual after downward balance", r - exact, 16'h0004);
  endtask

  task automatic t_both;
    logic [SUM_W-1:0] r;
    // block1 = C: low group stepped up by boundary 0, high group cleared by boundary 1
    run_one(16'h00C6, 3'b011, 3'b001, r);
    check("R8 both edits on one block", r, 16'h0016);
    check("R8 both edits vs prediction", r, predict(16'h00C6, 3'b011, 3'b001));
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_sum = 16'h1225; in_err = 3'b001; in_dir = 3'b001; in_valid = 1'b1;
    @(negedge clk);
    in_sum = 16'h6A3C; in_err = 3'b100; in_dir = 3'b000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream first word", out_sum, 16'h1235);
    @(negedge clk);
    check("R1 stream second word", out_sum, 16'h5A3C);
    check("R1 stream valid held", {15'd0, out_valid}, 16'd1);
    @(negedge clk);
    check("R1 stream valid drops", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_mixed;
    logic [SUM_W-1:0] r;
    logic [SUM_W-1:0] lfsr;
    logic [NUM_BND-1:0] f, d;
    lfsr = 16'hACE1;
    for (int i = 0; i < 8; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      f = lfsr[2:0] ^ lfsr[8:6];
      d = lfsr[5:3];
      run_one(lfsr, f, d, r);
      check("R3-R6 mixed flags vs prediction", r, predict(lfsr, f, d));
    end
  endtask

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_sum = '0; in_err = '0; in_dir = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pass();
    t_dir_ignored();
    t_inc();
    t_dec();
    t_bal_up();
    t_bal_down();
    t_both();
    t_stream();
    t_mixed();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule